// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the bank of 32-bit control words that a host bridge keeps for its own configuration. Software reaches it through a simple single-cycle register port: a request with an address, an access size, a write strobe and write data. A read returns the addressed word in the same cycle. The bank starts at byte offset 0x100 of the register window and spans 28 words. Only aligned 32-bit accesses reach it.

Most words hold plain read/write values with fixed reset defaults. The interrupt-enable word cannot be written directly. Two alias words change it instead: writing one ORs the data into the enable word, and writing the other clears the bits set in the data. The interrupt-status word is read-only. A write that moves bit 2 of the general-control word from 0 to 1 causes a one-cycle system reset request. The address-mapping and interrupt-configuration words are also driven out as ports, so that neighbouring blocks can use them.

Top module: `hb_ctrl_regs`

## Requirements
- R1: A word access at byte address 0x100 + 4k, for k from 0 to 27, selects word k. While `req_i` is high and `we_i` is low, `rdata_o` returns that word in the same cycle. In every other case `rdata_o` is 0.
- R2: After reset every word reads as its default value. The defaults that are not zero are:
  - word 0: 0x00000C40
  - word 1: 0x00001384
  - word 2: 0x2BFF8010
  - word 3: 0x255E0091
  - word 4: 0x00006140
  - word 7: 0x000001FF
  - word 8: 0x000001FF
  - word 26: 0x00000008
  - word 27: 0x10000000

  Every other word resets to 0.
- R3: A write to any word other than 14 and 15 stores `wdata_i` at the clock edge.
- R4: A write to word 12 (0x130) stores the data in word 12 and ORs the data into word 14.
- R5: A write to word 13 (0x134) stores the data in word 13 and clears in word 14 every bit that is set in the data.
- R6: Direct writes to word 14 (0x138, interrupt enable) and word 15 (0x13C, interrupt status) leave both words unchanged.
- R7: A write to word 1 (0x104) whose data has bit 2 set, while the stored bit 2 is 0, raises `sys_rst_req_o` for exactly the one cycle after that clock edge. The written value is stored in every case.
- R8: An access with `size_i` other than 2 (the code for 4 bytes; 0 means 1 byte and 1 means 2 bytes), or with `addr_i[1:0]` not 0, changes nothing and reads 0.
- R9: An access whose address lies below 0x100, or at 0x170 or above, changes nothing and reads 0.
- R10: Seven ports carry the current value of a word:

  | Port | Word | Address |
  |---|---|---|
  | `pci_map_o` | 4 | 0x110 |
  | `pci_mem_base_o` | 5 | 0x114 |
  | `pci_cfg_map_o` | 6 | 0x118 |
  | `irq_edge_o` | 9 | 0x124 |
  | `irq_steer_o` | 10 | 0x128 |
  | `irq_pol_o` | 11 | 0x12C |
  | `irq_en_o` | 14 | 0x138 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size as log2 of the byte count |
| addr_i | input | 12 | Byte address in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| pci_map_o | output | 32 | PCI map word |
| pci_mem_base_o | output | 32 | PCI memory base word |
| pci_cfg_map_o | output | 32 | PCI configuration map word |
| irq_edge_o | output | 32 | Interrupt edge-select word |
| irq_steer_o | output | 32 | Interrupt steering word |
| irq_pol_o | output | 32 | Interrupt polarity word |
| irq_en_o | output | 32 | Interrupt enable word |

## Verification
The assertions check several rules on every cycle:
- the enable word tracks its set and clear aliases;
- the enable word holds across a direct write;
- the reset request never lasts more than one cycle and always follows a write to the general-control word;
- reads that are unaligned or outside the bank return zero.

Only the bench scenarios can show the rest, by comparing against a reference model: the exact reset defaults, that plain words store their data, that the rising-edge rule fires only on a real 0-to-1 change, and that each side port follows its own word.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned IDX_GEN     = 1;
  localparam int unsigned IDX_PCIMAP  = 4;
  localparam int unsigned IDX_MEMBASE = 5;
  localparam int unsigned IDX_CFGMAP  = 6;
  localparam int unsigned IDX_EDGE    = 9;
  localparam int unsigned IDX_STEER   = 10;
  localparam int unsigned IDX_POL     = 11;
  localparam int unsigned IDX_EN_SET  = 12;
  localparam int unsigned IDX_EN_CLR  = 13;
  localparam int unsigned IDX_EN      = 14;
  localparam int unsigned IDX_ISR     = 15;
  localparam int unsigned RST_BIT     = 2;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t rst_value(int unsigned idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hb_addr_dec.sv
module hb_addr_dec #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h100,
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_ADDR + NUM_WORDS * 4);

  logic word_ok, in_bank;

  assign word_ok = (size_i == 2'd2) && (addr_i[1:0] == 2'b00);
  assign in_bank = (addr_i >= BASE_A) && (addr_i < END_A);
  assign hit_o   = word_ok && in_bank;
  assign idx_o   = IDX_W'((addr_i - BASE_A) >> 2);
endmodule

// File: rtl/hb_reg_bank.sv
module hb_reg_bank
  import hb_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  word_t                         wdata_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] regs_o
);
  logic set_wr, clr_wr;
  assign set_wr = wr_i && (idx_i == IDX_W'(IDX_EN_SET));
  assign clr_wr = wr_i && (idx_i == IDX_W'(IDX_EN_CLR));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == IDX_EN) begin : g_en
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_o[i] <= rst_value(i);
        else if (set_wr) regs_o[i] <= regs_o[i] | wdata_i;
        else if (clr_wr) regs_o[i] <= regs_o[i] & ~wdata_i;
      end
    end else if (i == IDX_ISR) begin : g_ro
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= rst_value(i);
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             regs_o[i] <= rst_value(i);
        else if (wr_i && idx_i == IDX_W'(i))     regs_o[i] <= wdata_i;
      end
    end
  end

  // R4
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> regs_o[IDX_EN] == ($past(regs_o[IDX_EN]) | $past(wdata_i)));
  // R5
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> regs_o[IDX_EN] == ($past(regs_o[IDX_EN]) & ~$past(wdata_i)));
  // R6
  en_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_W'(IDX_EN)) |=> $stable(regs_o[IDX_EN]));
endmodule

// File: rtl/hb_rst_req.sv
module hb_rst_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_gen_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= wr_gen_i && !old_bit_i && new_bit_i;
  end

  // R7
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R7
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(wr_gen_i) && !$past(old_bit_i));
endmodule

// File: rtl/hb_ctrl_regs.sv
module hb_ctrl_regs
  import hb_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h100,
  parameter int unsigned NUM_WORDS = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_req_o,
  output logic [31:0]       pci_map_o,
  output logic [31:0]       pci_mem_base_o,
  output logic [31:0]       pci_cfg_map_o,
  output logic [31:0]       irq_edge_o,
  output logic [31:0]       irq_steer_o,
  output logic [31:0]       irq_pol_o,
  output logic [31:0]       irq_en_o
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic                            hit, wr, rd;
  logic [IDX_W-1:0]                idx;
  logic [NUM_WORDS-1:0][DATA_W-1:0] regs;

  hb_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign wr = req_i && we_i && hit;
  assign rd = req_i && !we_i && hit;

  hb_reg_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  hb_rst_req u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_gen_i  (wr && idx == IDX_W'(IDX_GEN)),
    .old_bit_i (regs[IDX_GEN][RST_BIT]),
    .new_bit_i (wdata_i[RST_BIT]),
    .req_o     (sys_rst_req_o)
  );

  assign rdata_o        = rd ? regs[idx] : '0;
  assign pci_map_o      = regs[IDX_PCIMAP];
  assign pci_mem_base_o = regs[IDX_MEMBASE];
  assign pci_cfg_map_o  = regs[IDX_CFGMAP];
  assign irq_edge_o     = regs[IDX_EDGE];
  assign irq_steer_o    = regs[IDX_STEER];
  assign irq_pol_o      = regs[IDX_POL];
  assign irq_en_o       = regs[IDX_EN];

  // R8, R9
  miss_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |-> rdata_o == '0);
  // R9
  miss_wr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !hit) |=> $stable(irq_en_o));
endmodule

// File: tb/tb_hb_ctrl_regs.sv
module tb_hb_ctrl_regs;
  localparam int CLK_P = 10;
  localparam int NW    = 28;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [1:0]  size = 2;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, pmap, pmem, pcfg, iedge, isteer, ipol, ien;
  logic        rreq;

  int checks = 0, fails = 0;
  logic [31:0] m [NW];
  logic        exp_rreq = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sys_rst_req_o(rreq),
    .pci_map_o(pmap), .pci_mem_base_o(pmem), .pci_cfg_map_o(pcfg),
    .irq_edge_o(iedge), .irq_steer_o(isteer), .irq_pol_o(ipol), .irq_en_o(ien)
  );

  function automatic logic [31:0] def_val(int i);
    case (i)
      0: return 32'hC40;        1: return 32'h1384;
      2: return 32'h2BFF8010;   3: return 32'h255E0091;
      4: return 32'h6140;       7: return 32'h1FF;
      8: return 32'h1FF;        26: return 32'h8;
      27: return 32'h10000000;  default: return 0;
    endcase
  endfunction

  function automatic bit hits(logic [11:0] a, logic [1:0] s);
    return s == 2 && a[1:0] == 0 && a >= 12'h100 && a < 12'h170;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic chk_side();
    chk("R10 pci_map", pmap, m[4]);   chk("R10 mem_base", pmem, m[5]);
    chk("R10 cfg_map", pcfg, m[6]);   chk("R10 edge", iedge, m[9]);
    chk("R10 steer", isteer, m[10]);  chk("R10 pol", ipol, m[11]);
    chk("R10 en", ien, m[14]);
  endtask

  // drive on falling edge, model updates at rising edge, checks on next falling edge
  task automatic wr_op(logic [11:0] a, logic [31:0] d, logic [1:0] s, string r);
    int i;
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; size = s;
    exp_rreq = 0;
    if (hits(a, s)) begin
      i = int'((a - 12'h100) >> 2);
      case (i)
        12: begin m[12] = d; m[14] |= d; end
        13: begin m[13] = d; m[14] &= ~d; end
        14, 15: ;
        1: begin exp_rreq = !m[1][2] && d[2]; m[1] = d; end
        default: m[i] = d;
      endcase
    end
    @(negedge clk);
    req = 0; we = 0;
    chk({r, " R7 rst_req"}, {31'b0, rreq}, {31'b0, exp_rreq});
    chk_side();
  endtask

  task automatic rd_op(logic [11:0] a, logic [1:0] s, string r);
    @(negedge clk);
    req = 1; we = 0; addr = a; size = s;
    #1;
    chk(r, rdata, hits(a, s) ? m[int'((a - 12'h100) >> 2)] : 32'h0);
    chk({r, " R7 no pulse"}, {31'b0, rreq}, 32'h0);
    req = 0;
  endtask

  initial begin
    #(200000 * CLK_P);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NW; i++) m[i] = def_val(i);
    #(3 * CLK_P);
    rst_n = 1;
    @(negedge clk);
    chk("R2 rdata idle", rdata, 0);
    for (int i = 0; i < NW; i++) rd_op(12'h100 + 12'(4*i), 2, "R2 R1 reset value");
    chk_side();

    wr_op(12'h148, 32'hCAFE0001, 2, "R3");
    rd_op(12'h148, 2, "R3 mailbox readback");
    wr_op(12'h130, 32'h0000_00F0, 2, "R4");
    wr_op(12'h130, 32'h0000_0003, 2, "R4");
    rd_op(12'h138, 2, "R4 enable or");
    rd_op(12'h130, 2, "R4 alias stored");
    wr_op(12'h134, 32'h0000_0011, 2, "R5");
    rd_op(12'h138, 2, "R5 enable clear");
    rd_op(12'h134, 2, "R5 alias stored");
    wr_op(12'h138, 32'hFFFF_FFFF, 2, "R6");
    rd_op(12'h138, 2, "R6 enable ro");
    wr_op(12'h13C, 32'hFFFF_FFFF, 2, "R6");
    rd_op(12'h13C, 2, "R6 status ro");

    wr_op(12'h104, 32'h0000_1380, 2, "R7 clear bit");
    wr_op(12'h104, 32'h0000_0004, 2, "R7 rising");
    rd_op(12'h104, 2, "R7 value stored");
    wr_op(12'h104, 32'h0000_0004, 2, "R7 held high");

    wr_op(12'h110, 32'h1234_5678, 1, "R8 half");
    wr_op(12'h112, 32'h1234_5678, 2, "R8 misaligned");
    rd_op(12'h110, 2, "R8 unchanged");
    rd_op(12'h110, 0, "R8 byte read zero");
    wr_op(12'h170, 32'hDEAD_BEEF, 2, "R9 above");
    wr_op(12'h0FC, 32'hDEAD_BEEF, 2, "R9 below");
    rd_op(12'h170, 2, "R9 read above");
    rd_op(12'h0FC, 2, "R9 read below");

    for (int n = 0; n < 600; n++) begin
      int k;
      logic [11:0] a;
      logic [1:0]  s;
      k = int'($urandom % 10);
      s = 2;
      if (k == 0) a = ($urandom % 2) ? 12'h170 + 12'(4 * ($urandom % 32)) : 12'(4 * ($urandom % 64));
      else begin
        a = 12'h100 + 12'(4 * ($urandom % NW));
        if (k == 1) begin
          if ($urandom % 2) a = a + 12'(1 + $urandom % 3);
          else s = 2'($urandom % 2);
        end else if (k == 2) a = 12'h104;
        else if (k == 3) a = 12'h130 + 12'(4 * ($urandom % 4));
      end
      if ($urandom % 2) wr_op(a, $urandom, s, "R3 R4 R5 R6 R7 R8 R9 random");
      else              rd_op(a, s, "R1 R8 R9 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule